// File: doc/BRIEF.md
# Masked Control Register File

This block holds sixteen 32-bit processor control registers: the live status word, its two saved copies for exceptions and breaks, interrupt enable and pending words, a core identifier, an exception cause, the address-translation control words and a faulting-address register. Each register has a fixed writable mask and a fixed read-only mask. Two parameters select the masks: one says whether an external interrupt controller is fitted, the other whether address translation is fitted. Any bit in neither mask is reserved and always reads zero.

Software and debug writes go through one port that merges the incoming word with the masks. Writable bits come from the data. Read-only bits keep their current value. Reserved bits are cleared. A second port is for the core's own hardware, such as latching pending lines or an exception cause. It bypasses the writable and read-only split and keeps only the reserved-bit clearing. A combinational debug read port returns any register by index. A register with no bits in either mask is fully reserved and always reads zero.

Register index map (4 bits): 0 status, 1 saved status on exception, 2 saved status on break, 3 interrupt enable, 4 interrupt pending, 5 core id, 6 exception cause, 7 page-table address, 8 translation access, 9 translation misc, 10 faulting address, 11 to 15 always reserved.

Top module: `ctrl_regfile`

## Requirements
- R1: After reset every register reads zero, except status, which reads 0x0080_0000 (bit 23 set), and core id, which reads the CORE_ID parameter.
- R2: A software write (sw_we) to index i stores (sw_data AND writable(i)) OR (current AND read-only(i)). The result is visible on the debug port from the clock edge that takes the write.
- R3: Bits in neither mask always read zero. A register with both masks zero reads zero, and writes to it through either port have no effect. Indices 11 to 15 are always reserved.
- R4: In every configuration, status bit 0 is writable and all 32 bits of indices 1, 2 and 10 are writable. Indices 5 and 6 are fully read-only.
- R5: Without the external interrupt controller, status bit 23 is read-only, index 3 is fully writable and index 4 is fully read-only.
- R6: With the external interrupt controller, these status bits are writable: bit 23, bits 21:16, bits 9:4 and bit 3. Bit 22 and bits 15:10 are read-only. Indices 3 and 4 are reserved.
- R7: With translation, status bits 1 and 2 are writable, index 7 bits 31:2 are writable and index 8 is fully writable. Without translation, indices 7, 8 and 9 are reserved.
- R8: With translation, index 9 bits 3:0 are read-only and bits 23:4 are writable. Bits 31:24 are reserved.
- R9: A hardware write (hw_we) to index i stores hw_data AND (writable(i) OR read-only(i)), so it can set read-only bits. When both ports address the same index in one cycle, the hardware write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software/debug write strobe |
| sw_idx | input | 4 | Software/debug write index |
| sw_data | input | 32 | Software/debug write data |
| hw_we | input | 1 | Hardware update strobe |
| hw_idx | input | 4 | Hardware update index |
| hw_data | input | 32 | Hardware update data |
| dbg_idx | input | 4 | Debug read index |
| dbg_rdata | output | 32 | Debug read data |

## Verification
The assertions check on every cycle that a software write takes its writable bits from the data and keeps its read-only bits. They also check that a hardware write lands exactly as masked, that reserved bits stay zero in every register, and that the core id changes only by a hardware update. Only the bench scenarios can show the concrete mask values for each configuration, the reset contents, and that the hardware port wins a same-index collision. They also show that reserved indices and configuration-reserved registers read zero at the debug port. Two instances with opposite parameter settings receive the same stimulus.

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter bit          EXT_IRQ_CTRL = 1'b0,
  parameter bit          HAS_XLATE    = 1'b1,
  parameter int unsigned CORE_ID      = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_we,
  input  logic [3:0]  sw_idx,
  input  logic [31:0] sw_data,
  input  logic        hw_we,
  input  logic [3:0]  hw_idx,
  input  logic [31:0] hw_data,
  input  logic [3:0]  dbg_idx,
  output logic [31:0] dbg_rdata
);
  localparam int NREG = 16;

  localparam logic [3:0] I_STATUS = 4'd0, I_ESAVE = 4'd1, I_BSAVE = 4'd2,
                         I_IRQEN  = 4'd3, I_IRQPEND = 4'd4, I_COREID = 4'd5,
                         I_CAUSE  = 4'd6, I_PTADDR  = 4'd7, I_XACC  = 4'd8,
                         I_XMISC  = 4'd9, I_FAULTA  = 4'd10;

  localparam logic [31:0] ST_GIE     = 32'h0000_0001;
  localparam logic [31:0] ST_USER    = 32'h0000_0002;
  localparam logic [31:0] ST_EXCHDL  = 32'h0000_0004;
  localparam logic [31:0] ST_HANDLER = 32'h0000_0008;
  localparam logic [31:0] ST_LEVEL   = 32'h0000_03F0;
  localparam logic [31:0] ST_CURSET  = 32'h0000_FC00;
  localparam logic [31:0] ST_PRVSET  = 32'h003F_0000;
  localparam logic [31:0] ST_NMI     = 32'h0040_0000;
  localparam logic [31:0] ST_SETIE   = 32'h0080_0000;
  localparam logic [31:0] PT_FIELDS  = 32'hFFFF_FFFC;
  localparam logic [31:0] XM_FLAGS   = 32'h0000_000F;
  localparam logic [31:0] XM_CTRL    = 32'h00FF_FFF0;

  function automatic logic [31:0] wmask(input logic [3:0] i);
    logic [31:0] m;
    m = '0;
    case (i)
      I_STATUS: begin
        m = ST_GIE;
        if (EXT_IRQ_CTRL) m |= ST_SETIE | ST_PRVSET | ST_LEVEL | ST_HANDLER;
        if (HAS_XLATE)    m |= ST_USER | ST_EXCHDL;
      end
      I_ESAVE, I_BSAVE, I_FAULTA: m = '1;
      I_IRQEN:  m = EXT_IRQ_CTRL ? '0 : '1;
      I_PTADDR: m = HAS_XLATE ? PT_FIELDS : '0;
      I_XACC:   m = HAS_XLATE ? '1 : '0;
      I_XMISC:  m = HAS_XLATE ? XM_CTRL : '0;
      default:  m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] rmask(input logic [3:0] i);
    logic [31:0] m;
    m = '0;
    case (i)
      I_STATUS:          m = EXT_IRQ_CTRL ? (ST_NMI | ST_CURSET) : ST_SETIE;
      I_IRQPEND:         m = EXT_IRQ_CTRL ? '0 : '1;
      I_COREID, I_CAUSE: m = '1;
      I_XMISC:           m = HAS_XLATE ? XM_FLAGS : '0;
      default:           m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] rstval(input logic [3:0] i);
    if (i == I_STATUS) return ST_SETIE;
    if (i == I_COREID) return 32'(CORE_ID);
    return '0;
  endfunction

  logic [31:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)
        regs[i] <= rstval(4'(i));
      else if (hw_we && hw_idx == 4'(i))
        regs[i] <= hw_data & (wmask(4'(i)) | rmask(4'(i)));
      else if (sw_we && sw_idx == 4'(i))
        regs[i] <= (sw_data & wmask(4'(i))) | (regs[i] & rmask(4'(i)));
    end
  end

  assign dbg_rdata = ((wmask(dbg_idx) | rmask(dbg_idx)) == '0) ? '0 : regs[dbg_idx];

  logic sw_alone;
  assign sw_alone = sw_we && !(hw_we && hw_idx == sw_idx);

  assert_wr_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_alone |=> ((regs[$past(sw_idx)] & wmask($past(sw_idx))) ==
                  ($past(sw_data) & wmask($past(sw_idx)))));

  assert_ro_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_alone |=> ((regs[$past(sw_idx)] & rmask($past(sw_idx))) ==
                  ($past(regs[sw_idx]) & rmask($past(sw_idx)))));

  assert_hw_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_we |=> (regs[$past(hw_idx)] ==
               ($past(hw_data) & (wmask($past(hw_idx)) | rmask($past(hw_idx))))));

  assert_coreid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_we && hw_idx == I_COREID) |=> $stable(regs[I_COREID]));

  for (genvar g = 0; g < NREG; g++) begin : g_rsvd
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[g] & ~(wmask(4'(g)) | rmask(4'(g)))) == '0);
  end
endmodule

// File: tb/ctrl_regfile_tb.sv
module ctrl_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_we = 1'b0, hw_we = 1'b0;
  logic [3:0] sw_idx = '0, hw_idx = '0, dbg_idx = '0;
  logic [31:0] sw_data = '0, hw_data = '0;
  logic [31:0] rd_a, rd_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctrl_regfile #(.EXT_IRQ_CTRL(1'b0), .HAS_XLATE(1'b1), .CORE_ID(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_idx(sw_idx), .sw_data(sw_data),
    .hw_we(hw_we), .hw_idx(hw_idx), .hw_data(hw_data), .dbg_idx(dbg_idx), .dbg_rdata(rd_a));

  ctrl_regfile #(.EXT_IRQ_CTRL(1'b1), .HAS_XLATE(1'b0), .CORE_ID(7)) dut_eic_i (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_idx(sw_idx), .sw_data(sw_data),
    .hw_we(hw_we), .hw_idx(hw_idx), .hw_data(hw_data), .dbg_idx(dbg_idx), .dbg_rdata(rd_b));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, string req, logic [31:0] ea, logic [31:0] eb);
    dbg_idx = idx;
    #1;
    chk(req, $sformatf("A idx %0d", idx), rd_a, ea);
    chk(req, $sformatf("B idx %0d", idx), rd_b, eb);
  endtask

  task automatic swr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_idx = idx; sw_data = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic hwr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    hw_we = 1'b1; hw_idx = idx; hw_data = d;
    @(negedge clk);
    hw_we = 1'b0;
  endtask

  task automatic t_reset();
    rd(4'd0, "R1", 32'h0080_0000, 32'h0080_0000);
    rd(4'd5, "R1", 32'd3, 32'd7);
    rd(4'd1, "R1", 32'h0, 32'h0);
    rd(4'd9, "R1", 32'h0, 32'h0);
  endtask

  task automatic t_status();
    swr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, "R2", 32'h0080_0007, 32'h00BF_03F9);
    swr(4'd0, 32'h0000_0000);
    rd(4'd0, "R5", 32'h0080_0000, 32'h0000_0000);
    hwr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, "R9", 32'h0080_0007, 32'h00FF_FFF9);
    swr(4'd0, 32'h0000_0000);
    rd(4'd0, "R6", 32'h0080_0000, 32'h0040_FC00);
    swr(4'd0, 32'h0000_0001);
    rd(4'd0, "R4", 32'h0080_0001, 32'h0040_FC01);
  endtask

  task automatic t_fixed();
    swr(4'd1, 32'hDEAD_BEEF);
    rd(4'd1, "R4", 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    swr(4'd2, 32'h1234_5678);
    rd(4'd2, "R4", 32'h1234_5678, 32'h1234_5678);
    swr(4'd10, 32'hCAFE_F00D);
    rd(4'd10, "R4", 32'hCAFE_F00D, 32'hCAFE_F00D);
    swr(4'd5, 32'h1234_5678);
    rd(4'd5, "R4", 32'd3, 32'd7);
    hwr(4'd6, 32'h0000_001C);
    rd(4'd6, "R9", 32'h1C, 32'h1C);
    swr(4'd6, 32'hFFFF_0000);
    rd(4'd6, "R4", 32'h1C, 32'h1C);
  endtask

  task automatic t_irq();
    swr(4'd3, 32'h0000_F0F0);
    rd(4'd3, "R5", 32'h0000_F0F0, 32'h0);
    hwr(4'd4, 32'h0000_00A5);
    rd(4'd4, "R5", 32'h0000_00A5, 32'h0);
    swr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, "R5", 32'h0000_00A5, 32'h0);
  endtask

  task automatic t_xlate();
    swr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, "R7", 32'hFFFF_FFFC, 32'h0);
    swr(4'd8, 32'h8765_4321);
    rd(4'd8, "R7", 32'h8765_4321, 32'h0);
    hwr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, "R8", 32'h00FF_FFFF, 32'h0);
    swr(4'd9, 32'h0000_0000);
    rd(4'd9, "R8", 32'h0000_000F, 32'h0);
    swr(4'd9, 32'hFFFF_FFF0);
    rd(4'd9, "R8", 32'h00FF_FFFF, 32'h0);
  endtask

  task automatic t_reserved();
    for (int k = 11; k < 16; k++) begin
      swr(4'(k), 32'hFFFF_FFFF);
      hwr(4'(k), 32'hFFFF_FFFF);
      rd(4'(k), "R3", 32'h0, 32'h0);
    end
    hwr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, "R3", 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    sw_we = 1'b1; sw_idx = 4'd1; sw_data = 32'h1111_1111;
    hw_we = 1'b1; hw_idx = 4'd1; hw_data = 32'h2222_2222;
    @(negedge clk);
    sw_we = 1'b0; hw_we = 1'b0;
    rd(4'd1, "R9", 32'h2222_2222, 32'h2222_2222);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status();
    t_fixed();
    t_irq();
    t_xlate();
    t_reserved();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule